// File: doc/BRIEF.md
# Receive Ring Index Tracker

This block keeps track of how many entries of a receive descriptor ring are occupied. A hardware producer adds entries and moves a write index forward. A software consumer removes entries and moves a read index forward. The read index starts one position behind the write index. Because of that offset, the ring is full exactly when the two indices are equal, and no incrementing comparator is needed on the full path. The block drives registered empty, full and occupancy outputs. A produce attempt on a full ring is dropped and reported with a one-cycle overflow pulse.

Every accepted entry also receives a rolling, never-zero completion tag, which is shown on `prod_tag` at the moment the entry is produced. When the consumer takes an entry, it presents the tag it found in that entry. If the tag is not the one expected next, the data transfer for that entry has not landed yet. The block then refuses the consume and raises a mismatch pulse, and the consumer retries later. Descriptor storage and the transfer engine live outside this block.

Top module: `rx_ring_tracker`

## Requirements
- R1: After reset, `rd_idx` equals DEPTH-1, `wr_idx` equals 0, `empty` is 1, `full` is 0, `used_cnt` is 0, `prod_tag` is 1, and both pulse outputs are 0.
- R2: An accepted produce advances `wr_idx` by one, and an accepted consume advances `rd_idx` by one. Both indices wrap from DEPTH-1 to 0.
- R3: `full` is 1 exactly when `wr_idx` equals `rd_idx`. A produce request while `full` is 1 leaves `wr_idx` and `prod_tag` unchanged and sets `overflow` to 1 for the following cycle.
- R4: `used_cnt` equals (`wr_idx` - `rd_idx` - 1) mod DEPTH, so the ring holds at most DEPTH-1 entries. `empty` is 1 exactly when `used_cnt` is 0.
- R5: Tags are TAG_W bits wide (13 by default) and are issued in the order 1, 2, …, 2^TAG_W-1, 1, … Zero is never issued. `prod_tag` advances only on an accepted produce.
- R6: A consume request on a non-empty ring whose `cons_tag` differs from the next expected tag leaves `rd_idx` unchanged and sets `tag_mismatch` to 1 for the following cycle. The expected tag follows the same sequence as R5 and advances only on accepted consumes.
- R7: A consume request while `empty` is 1 changes no index and raises neither pulse, even if a produce arrives in the same cycle.
- R8: A produce and a consume in the same cycle are both accepted when the ring is neither full nor empty. `used_cnt` is then unchanged and both indices advance.
- R9: All status and pulse outputs are registered. They reflect a strobe sampled on a rising edge from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| prod_req | input | 1 | Producer adds one entry |
| cons_req | input | 1 | Consumer removes one entry |
| cons_tag | input | TAG_W | Tag read by the consumer from the entry it removes |
| prod_tag | output | TAG_W | Tag given to the entry produced in this cycle |
| wr_idx | output | $clog2(DEPTH) | Producer index |
| rd_idx | output | $clog2(DEPTH) | Consumer index |
| used_cnt | output | $clog2(DEPTH) | Occupied entries |
| empty | output | 1 | No entries held |
| full | output | 1 | DEPTH-1 entries held |
| overflow | output | 1 | Pulse: the previous produce was dropped |
| tag_mismatch | output | 1 | Pulse: the previous consume had a stale tag |

## Verification
Short directed runs check the documented occupancy sequence 0, 1, 2, 1, 0. They then fill the ring to capacity, so that the equal-index full rule is told apart from an off-by-one capacity. Produce and consume requests sent together at the full and empty edges show whether the block uses current state or next state to accept them. Corrupted tags separate a consume that was refused from one that was accepted. A long run of paired strobes carries the tag past 2^TAG_W-1 and shows whether zero is skipped. Random mixes of strobes with occasional bad tags then compare every output against a bench model on every cycle.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
   // Classification of one consume attempt
   typedef enum logic [1:0] {
      CONS_IDLE   = 2'd0,
      CONS_TAKE   = 2'd1,
      CONS_STALE  = 2'd2,
      CONS_VACANT = 2'd3
   } cons_kind_e;

   typedef struct packed {
      logic empty;
      logic full;
      logic overflow;
      logic mismatch;
   } ring_flags_t;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/ring_idx_ctr.sv
module ring_idx_ctr #(
   parameter int unsigned DEPTH     = 256,
   parameter int unsigned IDX_W     = $clog2(DEPTH),
   parameter int unsigned RESET_VAL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [IDX_W-1:0] idx,
   output logic [IDX_W-1:0] idx_nxt
);
   localparam logic [IDX_W-1:0] LAST  = IDX_W'(DEPTH - 1);
   localparam logic [IDX_W-1:0] START = IDX_W'(RESET_VAL);

   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] idx_inc;

   generate
      if (rx_ring_pkg::is_pow2(DEPTH)) begin : g_natural_wrap
         assign idx_inc = idx_q + 1'b1;
      end else begin : g_explicit_wrap
         assign idx_inc = (idx_q == LAST) ? '0 : idx_q + 1'b1;
      end
   endgenerate

   assign idx_nxt = adv ? idx_inc : idx_q;
   assign idx     = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idx_q <= START;
      else        idx_q <= idx_nxt;
   end
endmodule

// File: rtl/tag_seq.sv
module tag_seq #(
   parameter int unsigned TAG_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [TAG_W-1:0] tag
);
   localparam logic [TAG_W-1:0] TOP = {TAG_W{1'b1}};
   localparam logic [TAG_W-1:0] ONE = TAG_W'(1);

   logic [TAG_W-1:0] tag_q;
   logic [TAG_W-1:0] tag_inc;

   // Zero is skipped: after the all-ones value the sequence restarts at one.
   assign tag_inc = (tag_q == TOP) ? ONE : tag_q + 1'b1;
   assign tag     = tag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   tag_q <= ONE;
      else if (adv) tag_q <= tag_inc;
   end
endmodule

// File: rtl/ring_status.sv
module ring_status #(
   parameter int unsigned DEPTH = 256,
   parameter int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [IDX_W-1:0]        wr_nxt,
   input  logic [IDX_W-1:0]        rd_nxt,
   input  logic                    prod_drop,
   input  rx_ring_pkg::cons_kind_e cons_kind,
   output logic [IDX_W-1:0]        used_cnt,
   output rx_ring_pkg::ring_flags_t flags
);
   import rx_ring_pkg::*;

   localparam logic [IDX_W:0] DEP_X = (IDX_W + 1)'(DEPTH);

   logic [IDX_W-1:0] used_nxt;
   logic [IDX_W-1:0] used_q;
   ring_flags_t      flags_q;

   generate
      if (is_pow2(DEPTH)) begin : g_used_pow2
         assign used_nxt = wr_nxt - rd_nxt - 1'b1;
      end else begin : g_used_any
         logic [IDX_W:0] ext;
         always_comb begin
            ext = {1'b0, wr_nxt} - {1'b0, rd_nxt} - (IDX_W + 1)'(1);
            if (wr_nxt <= rd_nxt) ext = ext + DEP_X;
         end
         assign used_nxt = ext[IDX_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         used_q           <= '0;
         flags_q.empty    <= 1'b1;
         flags_q.full     <= 1'b0;
         flags_q.overflow <= 1'b0;
         flags_q.mismatch <= 1'b0;
      end else begin
         used_q           <= used_nxt;
         flags_q.empty    <= (used_nxt == '0);
         flags_q.full     <= (wr_nxt == rd_nxt);
         flags_q.overflow <= prod_drop;
         flags_q.mismatch <= (cons_kind == CONS_STALE);
      end
   end

   assign used_cnt = used_q;
   assign flags    = flags_q;
endmodule

// File: rtl/rx_ring_tracker.sv
module rx_ring_tracker #(
   parameter int unsigned DEPTH = 256,
   parameter int unsigned TAG_W = 13,
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             prod_req,
   input  logic             cons_req,
   input  logic [TAG_W-1:0] cons_tag,
   output logic [TAG_W-1:0] prod_tag,
   output logic [IDX_W-1:0] wr_idx,
   output logic [IDX_W-1:0] rd_idx,
   output logic [IDX_W-1:0] used_cnt,
   output logic             empty,
   output logic             full,
   output logic             overflow,
   output logic             tag_mismatch
);
   import rx_ring_pkg::*;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rx_ring_tracker: DEPTH must be at least 2");
      end
      if (TAG_W < 2) begin : g_bad_tag
         $error("rx_ring_tracker: TAG_W must be at least 2");
      end
   endgenerate

   logic [IDX_W-1:0] wr_nxt, rd_nxt;
   logic [TAG_W-1:0] exp_tag;
   logic             prod_ok, prod_drop, cons_ok;
   cons_kind_e       cons_kind;
   ring_flags_t      flags;

   // Acceptance uses the registered state of this cycle (R7, R8).
   assign prod_ok   = prod_req & ~flags.full;
   assign prod_drop = prod_req &  flags.full;

   always_comb begin
      if (!cons_req)              cons_kind = CONS_IDLE;
      else if (flags.empty)       cons_kind = CONS_VACANT;
      else if (cons_tag != exp_tag) cons_kind = CONS_STALE;
      else                        cons_kind = CONS_TAKE;
   end
   assign cons_ok = (cons_kind == CONS_TAKE);

   ring_idx_ctr #(.DEPTH(DEPTH), .IDX_W(IDX_W), .RESET_VAL(0)) u_wr (
      .clk(clk), .rst_n(rst_n), .adv(prod_ok), .idx(wr_idx), .idx_nxt(wr_nxt)
   );

   ring_idx_ctr #(.DEPTH(DEPTH), .IDX_W(IDX_W), .RESET_VAL(DEPTH - 1)) u_rd (
      .clk(clk), .rst_n(rst_n), .adv(cons_ok), .idx(rd_idx), .idx_nxt(rd_nxt)
   );

   tag_seq #(.TAG_W(TAG_W)) u_ptag (
      .clk(clk), .rst_n(rst_n), .adv(prod_ok), .tag(prod_tag)
   );

   tag_seq #(.TAG_W(TAG_W)) u_ctag (
      .clk(clk), .rst_n(rst_n), .adv(cons_ok), .tag(exp_tag)
   );

   ring_status #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .wr_nxt(wr_nxt), .rd_nxt(rd_nxt),
      .prod_drop(prod_drop), .cons_kind(cons_kind),
      .used_cnt(used_cnt), .flags(flags)
   );

   assign empty        = flags.empty;
   assign full         = flags.full;
   assign overflow     = flags.overflow;
   assign tag_mismatch = flags.mismatch;
endmodule

// File: rtl/rx_ring_tracker_chk.sv
module rx_ring_tracker_chk #(
   parameter int unsigned DEPTH = 256,
   parameter int unsigned TAG_W = 13,
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             prod_req,
   input logic             cons_req,
   input logic [TAG_W-1:0] prod_tag,
   input logic [IDX_W-1:0] wr_idx,
   input logic [IDX_W-1:0] rd_idx,
   input logic [IDX_W-1:0] used_cnt,
   input logic             empty,
   input logic             full,
   input logic             overflow,
   input logic             tag_mismatch
);
   p_full_equal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> (wr_idx == rd_idx));

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (prod_req && full) |=> ($stable(wr_idx) && $stable(prod_tag) && overflow));

   p_empty_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> (used_cnt == '0));

   p_tag_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      prod_tag != '0);

   p_stale_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tag_mismatch |-> $stable(rd_idx));

   p_vacant_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cons_req && empty) |=> ($stable(rd_idx) && !tag_mismatch));

   p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(empty && full));
endmodule

bind rx_ring_tracker rx_ring_tracker_chk #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .prod_req(prod_req), .cons_req(cons_req),
   .prod_tag(prod_tag), .wr_idx(wr_idx), .rd_idx(rd_idx), .used_cnt(used_cnt),
   .empty(empty), .full(full), .overflow(overflow), .tag_mismatch(tag_mismatch)
);

// File: tb/rx_ring_tracker_tb.sv
module rx_ring_tracker_tb;
   localparam int DEPTH = 256;
   localparam int TAG_W = 13;
   localparam int IDX_W = $clog2(DEPTH);
   localparam int TAG_TOP = (1 << TAG_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic prod_req = 1'b0, cons_req = 1'b0;
   logic [TAG_W-1:0] cons_tag = '0;
   logic [TAG_W-1:0] prod_tag;
   logic [IDX_W-1:0] wr_idx, rd_idx, used_cnt;
   logic empty, full, overflow, tag_mismatch;

   int n_chk = 0, n_bad = 0;

   // bench model
   int m_wr, m_rd, m_ptag, m_ctag;
   int m_ovf, m_mis;
   int entry_tag [DEPTH];

   always #5 clk = ~clk;

   rx_ring_tracker #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .prod_req(prod_req), .cons_req(cons_req),
      .cons_tag(cons_tag), .prod_tag(prod_tag), .wr_idx(wr_idx), .rd_idx(rd_idx),
      .used_cnt(used_cnt), .empty(empty), .full(full), .overflow(overflow),
      .tag_mismatch(tag_mismatch)
   );

   function automatic int used_of(int w, int r);
      return (w - r - 1 + 2 * DEPTH) % DEPTH;
   endfunction

   function automatic int tag_after(int t);
      return (t == TAG_TOP) ? 1 : t + 1;
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_all(string req);
      chk("R2", {req, " wr_idx"}, int'(wr_idx), m_wr);
      chk("R2", {req, " rd_idx"}, int'(rd_idx), m_rd);
      chk("R4", {req, " used_cnt"}, int'(used_cnt), used_of(m_wr, m_rd));
      chk("R4", {req, " empty"}, int'(empty), int'(used_of(m_wr, m_rd) == 0));
      chk("R3", {req, " full"}, int'(full), int'(m_wr == m_rd));
      chk("R3", {req, " overflow"}, int'(overflow), m_ovf);
      chk("R6", {req, " tag_mismatch"}, int'(tag_mismatch), m_mis);
      chk("R5", {req, " prod_tag"}, int'(prod_tag), m_ptag);
   endtask

   // One clock: drive at the falling edge, check at the next falling edge (R9)
   task automatic step(bit p, bit c, bit bad, string req);
      int  nxt_rd, tin;
      bit  is_full, is_empty, pok, cok;
      nxt_rd   = (m_rd + 1) % DEPTH;
      tin      = entry_tag[nxt_rd];
      if (bad) tin = (tin == TAG_TOP) ? 1 : tin + 1;
      is_full  = (m_wr == m_rd);
      is_empty = (used_of(m_wr, m_rd) == 0);
      prod_req = p;
      cons_req = c;
      cons_tag = TAG_W'(tin);
      pok   = p && !is_full;
      cok   = c && !is_empty && (tin == m_ctag);
      m_ovf = int'(p && is_full);
      m_mis = int'(c && !is_empty && (tin != m_ctag));
      if (pok) begin
         entry_tag[m_wr] = m_ptag;
         m_wr   = (m_wr + 1) % DEPTH;
         m_ptag = tag_after(m_ptag);
      end
      if (cok) begin
         m_rd   = nxt_rd;
         m_ctag = tag_after(m_ctag);
      end
      @(posedge clk);
      @(negedge clk);
      check_all(req);
   endtask

   initial begin
      #3_000_000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0A11));
      for (int i = 0; i < DEPTH; i++) entry_tag[i] = 0;
      m_wr = 0; m_rd = DEPTH - 1; m_ptag = 1; m_ctag = 1; m_ovf = 0; m_mis = 0;

      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "rd_idx", int'(rd_idx), DEPTH - 1);
      chk("R1", "wr_idx", int'(wr_idx), 0);
      chk("R1", "empty", int'(empty), 1);
      chk("R1", "full", int'(full), 0);
      chk("R1", "used_cnt", int'(used_cnt), 0);
      chk("R1", "prod_tag", int'(prod_tag), 1);
      chk("R1", "pulses", int'(overflow | tag_mismatch), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Occupancy sequence 0,1,2,1,0 (R2, R4)
      step(1, 0, 0, "R2 produce1");  chk("R4", "seq used 1", int'(used_cnt), 1);
      step(1, 0, 0, "R2 produce2");  chk("R4", "seq used 2", int'(used_cnt), 2);
      step(0, 1, 0, "R2 consume1");  chk("R4", "seq used 1b", int'(used_cnt), 1);
      step(0, 1, 0, "R2 consume2");  chk("R4", "seq used 0", int'(used_cnt), 0);

      // R7: consume on empty, alone and with a produce
      step(0, 1, 0, "R7 empty consume");
      chk("R7", "no mismatch on empty", int'(tag_mismatch), 0);
      step(1, 1, 0, "R7 empty consume with produce");
      chk("R7", "rd held", int'(rd_idx), 1);

      // Fill to capacity (R3, R4)
      while (used_of(m_wr, m_rd) < DEPTH - 1) step(1, 0, 0, "R3 fill");
      chk("R3", "full at capacity", int'(full), 1);
      chk("R4", "used at capacity", int'(used_cnt), DEPTH - 1);
      step(1, 0, 0, "R3 produce on full");
      chk("R3", "overflow pulse", int'(overflow), 1);
      step(0, 0, 0, "R3 pulse clears");
      // produce and consume together on full: produce dropped, consume taken
      step(1, 1, 0, "R8 pair on full");
      chk("R3", "pair on full overflow", int'(overflow), 1);

      // R6: stale tag refused, then retry succeeds
      step(0, 1, 1, "R6 stale tag");
      chk("R6", "mismatch pulse", int'(tag_mismatch), 1);
      step(0, 1, 0, "R6 retry");
      chk("R6", "retry clean", int'(tag_mismatch), 0);

      // Drain
      while (used_of(m_wr, m_rd) > 0) step(0, 1, 0, "R2 drain");

      // R5 + R8: paired strobes carry the tag past its top value
      step(1, 0, 0, "R8 prime");
      for (int i = 0; i < TAG_TOP + 40; i++) step(1, 1, 0, "R8 R5 pair");
      chk("R8", "pair keeps used", int'(used_cnt), 1);

      // Random mix
      for (int i = 0; i < 6000; i++) begin
         int ph = (i / 500) % 3;
         bit p = ($urandom_range(99) < (ph == 0 ? 70 : (ph == 1 ? 30 : 50)));
         bit c = ($urandom_range(99) < (ph == 0 ? 30 : (ph == 1 ? 70 : 50)));
         bit b = ($urandom_range(99) < 8);
         step(p, c, b, "R9 random");
      end
      step(0, 0, 0, "R9 idle");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule